// File: doc/BRIEF.md
# Selectable Sequence Counter

A four-bit counter whose single state register can follow one of six fixed cyclic orders: plain binary, a three-bit reflected code in a fixed order, a rotating one-hot ring, a decimal decade, a twisted-ring (Johnson) shift and a four-state two-bit pseudo-random cycle. Each order is a Moore machine whose state diagram is one ring. The state register drives the output directly.

A three-bit selector picks the order. The block captures the selector only while the synchronous reset is high. The state then advances one place on every rising clock edge on which the count enable is high. A registered wrap flag marks the step from the last member of the ring back to the first, so a controller can use the block as a cycle counter or as a sequencer that drives a decoder. If the state register ever holds a pattern that is not a member of the chosen ring, the next enabled edge returns it to the ring's first member. This makes every mode self-starting.

Top module: `seqcnt_top`

## Requirements
- R1: While `rst` is high at a rising edge, the counter latches `mode_sel`, loads the first state of that mode and clears `wrap_o`. This holds even if `cnt_en` is high, and also in the middle of a run.
- R2: On a rising edge with `cnt_en` low and `rst` low, `state_o` keeps its value and `wrap_o` goes low.
- R3: Mode code 0 (binary) counts 0000, 0001, ... 1111 and then returns to 0000. The first state is 0000.
- R4: Mode code 1 (reflected code) holds bit 3 at 0 and steps bits 2..0 through 000, 010, 110, 100, 101, 111, 011, 001 before repeating. The first state is 0000.
- R5: Mode code 2 (one-hot ring) steps through 0001, 0010, 0100, 1000 and repeats, with exactly one bit set at all times. The first state is 0001.
- R6: Mode code 3 (decade) counts 0000 up to 1001 and then returns to 0000.
- R7: Mode code 4 (twisted ring) starts at 0000. Each step shifts right by one and feeds the inverse of bit 0 into bit 3, giving 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001 and repeat.
- R8: Mode code 5 (pseudo-random) holds bits 3..2 at 0 and steps bits 1..0 through 10, 01, 00, 11 before repeating. The first state is 0010.
- R9: `wrap_o` is high for exactly the one cycle after an enabled edge that moved the state from the mode's last member to its first member. It is low at all other times.
- R10: Changes on `mode_sel` while `rst` is low have no effect on the sequence.
- R11: The unused mode codes 6 and 7 behave exactly like binary mode.
- R12: `state_o` is always a member of the selected mode's ring. An illegal pattern is replaced by the first state on the next enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also samples the mode |
| cnt_en | input | 1 | Count enable; the state advances only when high |
| mode_sel | input | 3 | Sequence selector, sampled during reset |
| state_o | output | 4 | Current state of the selected ring |
| wrap_o | output | 1 | One-cycle flag after returning to the first state |

## Verification
The bench runs every mode, including both unused codes, through two full rings and one extra step. This separates the per-mode next-state rules and shows that each ring closes at its own length: 16, 10, 8 or 4. A decade run paused on intermediate states and on its last state separates the enable gating from the wrap logic. The same run shows that the wrap flag follows the wrap step itself and does not simply track the state value. Moving the selector after reset, and resetting in the middle of a run into a different mode, separate the reset-time capture of the mode from any live decoding of it.

// File: rtl/seqcnt_pkg.sv
package seqcnt_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_BIN   = 3'd0,
    MODE_GRAY  = 3'd1,
    MODE_RING  = 3'd2,
    MODE_DEC   = 3'd3,
    MODE_TWIST = 3'd4,
    MODE_PRNG  = 3'd5
  } seq_mode_e;

  // Step of the three-bit reflected code in its fixed order.
  function automatic logic [2:0] gray_step(input logic [2:0] g);
    logic [2:0] r;
    case (g)
      3'b000:  r = 3'b010;
      3'b010:  r = 3'b110;
      3'b110:  r = 3'b100;
      3'b100:  r = 3'b101;
      3'b101:  r = 3'b111;
      3'b111:  r = 3'b011;
      3'b011:  r = 3'b001;
      default: r = 3'b000;
    endcase
    return r;
  endfunction

  // Step of the two-bit pseudo-random cycle.
  function automatic logic [1:0] prng_step(input logic [1:0] p);
    logic [1:0] r;
    case (p)
      2'b10:   r = 2'b01;
      2'b01:   r = 2'b00;
      2'b00:   r = 2'b11;
      default: r = 2'b10;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/seqcnt_mode_latch.sv
module seqcnt_mode_latch
  import seqcnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_i,
  output seq_mode_e         mode_d,
  output seq_mode_e         mode_q
);

  // Decode the raw selector; unused codes fall back to binary.
  always_comb begin
    case (mode_i)
      3'd1:    mode_d = MODE_GRAY;
      3'd2:    mode_d = MODE_RING;
      3'd3:    mode_d = MODE_DEC;
      3'd4:    mode_d = MODE_TWIST;
      3'd5:    mode_d = MODE_PRNG;
      default: mode_d = MODE_BIN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= mode_d;
  end

  // R10: the captured mode only moves under reset
  assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_q));

endmodule

// File: rtl/seqcnt_ring_logic.sv
module seqcnt_ring_logic
  import seqcnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  seq_mode_e        mode,
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] first,
  output logic [WIDTH-1:0] nxt,
  output logic             legal,
  output logic             wrap_step
);

  localparam int GRAY_W = 3;
  localparam int PRNG_W = 2;
  localparam int DEC_W  = 4;
  localparam int EDGES  = WIDTH - 1;
  localparam logic [WIDTH-1:0] DEC_LAST = WIDTH'(9);

  // Twisted-ring legality: at most one boundary between neighbouring bits.
  logic [EDGES-1:0] bit_edge;
  for (genvar i = 0; i < EDGES; i++) begin : g_edge
    assign bit_edge[i] = cur[i] ^ cur[i+1];
  end
  logic twist_ok;
  assign twist_ok = ($countones(bit_edge) <= 1);

  logic upper_gray_zero, upper_prng_zero, upper_dec_zero;
  assign upper_gray_zero = (cur[WIDTH-1:GRAY_W] == '0);
  assign upper_prng_zero = (cur[WIDTH-1:PRNG_W] == '0);
  if (WIDTH > DEC_W) begin : g_dec_hi
    assign upper_dec_zero = (cur[WIDTH-1:DEC_W] == '0);
  end else begin : g_dec_fit
    assign upper_dec_zero = 1'b1;
  end

  logic [WIDTH-1:0] step;
  logic [WIDTH-1:0] last_v;

  always_comb begin
    first  = '0;
    last_v = '1;
    step   = cur + 1'b1;
    legal  = 1'b1;
    case (mode)
      MODE_GRAY: begin
        last_v = WIDTH'(3'b001);
        step   = WIDTH'(gray_step(cur[GRAY_W-1:0]));
        legal  = upper_gray_zero;
      end
      MODE_RING: begin
        first  = WIDTH'(1);
        last_v = WIDTH'(1) << (WIDTH - 1);
        step   = {cur[WIDTH-2:0], cur[WIDTH-1]};
        legal  = $onehot(cur);
      end
      MODE_DEC: begin
        last_v = DEC_LAST;
        step   = cur + 1'b1;
        legal  = upper_dec_zero && (cur[DEC_W-1:0] <= 4'd9);
      end
      MODE_TWIST: begin
        last_v = WIDTH'(1);
        step   = {~cur[0], cur[WIDTH-1:1]};
        legal  = twist_ok;
      end
      MODE_PRNG: begin
        first  = WIDTH'(2'b10);
        last_v = WIDTH'(2'b11);
        step   = WIDTH'(prng_step(cur[PRNG_W-1:0]));
        legal  = upper_prng_zero;
      end
      default: begin
        first  = '0;
        last_v = '1;
        step   = cur + 1'b1;
        legal  = 1'b1;
      end
    endcase
  end

  assign wrap_step = legal && (cur == last_v);
  assign nxt       = (!legal || wrap_step) ? first : step;

endmodule

// File: rtl/seqcnt_state_reg.sv
module seqcnt_state_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] first,
  input  logic [WIDTH-1:0] nxt,
  input  logic             wrap_step,
  output logic [WIDTH-1:0] state_q,
  output logic             wrap_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= first;
      wrap_q  <= 1'b0;
    end else if (en) begin
      state_q <= nxt;
      wrap_q  <= wrap_step;
    end else begin
      wrap_q  <= 1'b0;
    end
  end

  // R2: no enable, no movement
  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state_q));

  // R9: the flag only ever sits on the first state
  assert_wrap_on_first_R9: assert property (@(posedge clk) disable iff (rst)
    wrap_q |-> (state_q == first));

  // R9: the flag never lasts two cycles
  assert_wrap_single_R9: assert property (@(posedge clk) disable iff (rst)
    wrap_q |=> !wrap_q);

endmodule

// File: rtl/seqcnt_top.sv
module seqcnt_top
  import seqcnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [2:0]       mode_sel,
  output logic [WIDTH-1:0] state_o,
  output logic             wrap_o
);

  seq_mode_e        mode_d, mode_q, mode_now;
  logic [WIDTH-1:0] first, nxt;
  logic             legal, wrap_step;

  seqcnt_mode_latch u_mode (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode_sel),
    .mode_d (mode_d),
    .mode_q (mode_q)
  );

  // During reset the incoming selector picks the first state.
  assign mode_now = rst ? mode_d : mode_q;

  seqcnt_ring_logic #(.WIDTH(WIDTH)) u_ring (
    .mode      (mode_now),
    .cur       (state_o),
    .first     (first),
    .nxt       (nxt),
    .legal     (legal),
    .wrap_step (wrap_step)
  );

  seqcnt_state_reg #(.WIDTH(WIDTH)) u_state (
    .clk       (clk),
    .rst       (rst),
    .en        (cnt_en),
    .first     (first),
    .nxt       (nxt),
    .wrap_step (wrap_step),
    .state_q   (state_o),
    .wrap_q    (wrap_o)
  );

  // R12: the register never leaves the selected ring
  assert_state_legal_R12: assert property (@(posedge clk) disable iff (rst)
    legal);

  // R5: one-hot mode keeps exactly one bit set
  assert_ring_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RING) |-> ($countones(state_o) == 1));

  // R3: binary mode adds one per enabled edge
  assert_bin_step_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_BIN) && cnt_en |=> state_o == WIDTH'($past(state_o) + 1'b1));

  // R7: twisted ring shifts right with inverted feedback
  assert_twist_step_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_TWIST) && cnt_en |=>
      state_o == {~$past(state_o[0]), $past(state_o[WIDTH-1:1])});

endmodule

// File: tb/seqcnt_top_test.sv
module seqcnt_top_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic [2:0] mode_sel = 3'd0;
  logic [3:0] state_o;
  logic       wrap_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  seqcnt_top #(.WIDTH(4)) uut (
    .clk      (clk),
    .rst      (rst),
    .cnt_en   (cnt_en),
    .mode_sel (mode_sel),
    .state_o  (state_o),
    .wrap_o   (wrap_o)
  );

  function automatic int ring_len(input logic [2:0] m);
    case (m)
      3'd1, 3'd4: return 8;
      3'd2, 3'd5: return 4;
      3'd3:       return 10;
      default:    return 16;
    endcase
  endfunction

  function automatic logic [3:0] ring_at(input logic [2:0] m, input int i);
    case (m)
      3'd1: case (i)
              0: return 4'b0000; 1: return 4'b0010; 2: return 4'b0110; 3: return 4'b0100;
              4: return 4'b0101; 5: return 4'b0111; 6: return 4'b0011; default: return 4'b0001;
            endcase
      3'd2: return 4'b0001 << i;
      3'd3: return 4'(i);
      3'd4: case (i)
              0: return 4'b0000; 1: return 4'b1000; 2: return 4'b1100; 3: return 4'b1110;
              4: return 4'b1111; 5: return 4'b0111; 6: return 4'b0011; default: return 4'b0001;
            endcase
      3'd5: case (i)
              0: return 4'b0010; 1: return 4'b0001; 2: return 4'b0000; default: return 4'b0011;
            endcase
      default: return 4'(i);
    endcase
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [2:0] m, input logic en_during);
    @(negedge clk);
    rst = 1'b1; mode_sel = m; cnt_en = en_during;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; cnt_en = 1'b0;
  endtask

  task automatic step(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  // R1: reset state of every mode
  task automatic test_reset_states();
    for (int m = 0; m < 6; m++) begin
      do_reset(3'(m), 1'b0);
      check("R1 first state", state_o, ring_at(3'(m), 0));
      check("R1 wrap low", {3'b0, wrap_o}, 4'b0);
    end
  endtask

  // R3..R9, R11, R12: two full rings plus one step
  task automatic run_mode(input logic [2:0] m, input string tag);
    int idx = 0;
    int len = ring_len(m);
    do_reset(m, 1'b0);
    cnt_en = 1'b1;
    for (int s = 0; s < 2 * len + 1; s++) begin
      @(negedge clk);
      idx = (idx + 1) % len;
      check(tag, state_o, ring_at(m, idx));
      check("R9 wrap", {3'b0, wrap_o}, {3'b0, (idx == 0)});
      begin
        bit member = 1'b0;
        for (int k = 0; k < len; k++) if (state_o == ring_at(m, k)) member = 1'b1;
        check("R12 membership", {3'b0, member}, 4'b0001);
      end
    end
    cnt_en = 1'b0;
  endtask

  // R2, R9: pauses in decade mode
  task automatic test_hold();
    do_reset(3'd3, 1'b0);
    step(3);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R2 hold mid", state_o, 4'd3);
      check("R2 wrap idle", {3'b0, wrap_o}, 4'b0);
    end
    step(6);
    check("R6 at last", state_o, 4'd9);
    @(negedge clk);
    @(negedge clk);
    check("R2 hold last", state_o, 4'd9);
    check("R9 no wrap while paused", {3'b0, wrap_o}, 4'b0);
    step(1);
    check("R6 decade rollover", state_o, 4'd0);
    check("R9 wrap after rollover", {3'b0, wrap_o}, 4'b0001);
    @(negedge clk);
    check("R9 wrap one cycle", {3'b0, wrap_o}, 4'b0);
    check("R2 hold after wrap", state_o, 4'd0);
  endtask

  // R10: selector moves after reset
  task automatic test_mode_ignored();
    do_reset(3'd2, 1'b0);
    mode_sel = 3'd3;
    cnt_en = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 3) mode_sel = 3'd0;
      check("R10 ring continues", state_o, ring_at(3'd2, k % 4));
    end
    cnt_en = 1'b0;
  endtask

  // R1: reset in mid-run with enable high, into another mode
  task automatic test_mid_reset();
    do_reset(3'd0, 1'b0);
    step(15);
    check("R3 at all ones", state_o, 4'b1111);
    do_reset(3'd5, 1'b1);
    check("R1 mid-run reload", state_o, 4'b0010);
    check("R1 wrap cleared", {3'b0, wrap_o}, 4'b0);
    step(1);
    check("R8 after mid reset", state_o, 4'b0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset_states();
    run_mode(3'd0, "R3 binary");
    run_mode(3'd1, "R4 reflected");
    run_mode(3'd2, "R5 one-hot");
    run_mode(3'd3, "R6 decade");
    run_mode(3'd4, "R7 twisted");
    run_mode(3'd5, "R8 pseudo-random");
    run_mode(3'd6, "R11 code 6");
    run_mode(3'd7, "R11 code 7");
    test_hold();
    test_mode_ignored();
    test_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule